// File: doc/BRIEF.md
# Oversampled Transparent Serial Transmit Input

This block takes a raw serial bit stream that a host drives on one input pin while the transmitter is placed in its transparent mode, and turns it into a clean stream of recovered bits for the modulator that follows. The pin first passes through a two-flop synchroniser. It is then sampled once per oversampling tick, and the tick runs at eight times the programmed bit rate. Each recovered bit is the majority of the three samples in the middle of its eight-sample window, and the block presents it on `bit_out` with a one-clock `bit_valid` pulse.

The host does not send any framing. It selects the transparent mode through a 2-bit format field (value 3), then starts the stream with a start strobe and stops it with an idle strobe. No buffering, packet handling, whitening, interleaving or error coding sits in this path. The host's bit period may differ from the nominal one by less than one eighth of a bit. The sample-phase counter locks again onto every input transition that falls outside the voting window, so a small, steady timing error never builds up into a dropped or a doubled bit.

Top module: `txin_oversampler`

## Requirements
- R1: After reset, `bit_valid` is 0 and `bit_out` is 0.
- R2: A start strobe begins transmission only while `fmt_sel` equals 3. A start strobe given with any other `fmt_sel` value produces no `bit_valid` pulse.
- R3: An idle strobe ends transmission. From then on `bit_valid` stays low and the phase counter rests at 0. When an idle strobe and a start strobe arrive in the same cycle, the idle strobe wins.
- R4: If `fmt_sel` moves away from 3 during transmission, transmission ends. It does not resume when `fmt_sel` returns to 3; a new start strobe is needed.
- R5: While the line is held steady during transmission, one bit is recovered every eight ticks (32 clocks when a tick comes every 4 clocks), and each bit equals the line level.
- R6: A recovered bit is the majority of samples 3, 4 and 5 of its window, with sample 0 being the first sample of the window. A disturbance of a single sample inside that window neither changes the bit nor realigns the phase.
- R7: An input transition seen at phase 6, 7, 0, 1 or 2 realigns the phase so that the sample showing the transition becomes sample 0. A transition seen at phase 6 first releases the pending bit. With the nominal bit period, a stream whose first bit is 0, sent after an idle-high line, is recovered bit for bit, in order and least significant bit first.
- R8: A host bit period of 15/16 or 17/16 of nominal, with runs of no more than three equal bits, is still recovered bit for bit.
- R9: `bit_valid` lasts exactly one clock and only ever follows a clock in which `os_tick` was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| data_pin | input | 1 | Asynchronous serial data from the host |
| os_tick | input | 1 | One-clock tick at eight times the bit rate |
| fmt_sel | input | 2 | Packet format field; 3 selects the transparent mode |
| start_stb | input | 1 | Start-transmit strobe |
| idle_stb | input | 1 | Go-idle strobe |
| bit_out | output | 1 | Last recovered bit |
| bit_valid | output | 1 | One-clock pulse marking a new `bit_out` |

## Verification
The bench sends streams at a host period that is slightly fast and at one that is slightly slow. A design that failed to realign, or that realigned without first releasing the pending bit, would drop or repeat bits there. It places a one-sample glitch right in the voting window. A design that voted on the wrong samples, or that realigned on that glitch, would flip the bit or shift every bit after it. It also checks that the idle strobe, a format change, a start strobe given in the wrong mode, and a start and idle strobe in the same cycle all leave the line silent. A gate that ignored any one of them would keep producing valid pulses.

// File: rtl/txin_pkg.sv
package txin_pkg;
    localparam int unsigned SYNC_STAGES = 2;
    localparam int unsigned FMT_W       = 2;

    function automatic logic vote3(input logic [2:0] v);
        return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
    endfunction
endpackage

// File: rtl/txin_sync.sv
module txin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (STAGES > 1) begin
            s_d.chain = {s_q.chain[STAGES-2:0], din};
        end else begin
            s_d.chain[0] = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dout = s_q.chain[STAGES-1];
endmodule

// File: rtl/txin_gate.sv
module txin_gate #(
    parameter int unsigned FMT_W   = 2,
    parameter int unsigned FMT_RAW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FMT_W-1:0] fmt_sel,
    input  logic             start_stb,
    input  logic             idle_stb,
    output logic             tx_on
);
    localparam logic [FMT_W-1:0] RAW_CODE = FMT_W'(FMT_RAW);

    typedef struct packed {
        logic on;
    } gate_t;

    gate_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (idle_stb || (fmt_sel != RAW_CODE)) begin
            g_d.on = 1'b0;
        end else if (start_stb) begin
            g_d.on = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign tx_on = g_q.on;

    assert_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_on) |-> $past(start_stb && (fmt_sel == RAW_CODE)));
    assert_idle_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        idle_stb |=> !tx_on);
    assert_mode_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_sel != RAW_CODE) |=> !tx_on);
endmodule

// File: rtl/txin_recover.sv
module txin_recover #(
    parameter int unsigned OSR = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_on,
    input  logic os_tick,
    input  logic samp,
    output logic bit_out,
    output logic bit_valid
);
    localparam int unsigned PH_W = $clog2(OSR);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);
    localparam logic [PH_W-1:0] PH_LATE = PH_W'(OSR - 2);
    localparam logic [PH_W-1:0] V_LO    = PH_W'(OSR / 2 - 1);
    localparam logic [PH_W-1:0] V_MID   = PH_W'(OSR / 2);
    localparam logic [PH_W-1:0] V_HI    = PH_W'(OSR / 2 + 1);

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic            last;
        logic [2:0]      votes;
        logic            bitv;
        logic            valid;
    } rec_t;

    rec_t r_d, r_q;
    logic            edge_seen;
    logic            realign;
    logic            emit;
    logic [PH_W-1:0] idx;

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        edge_seen = samp != r_q.last;
        realign   = edge_seen && !((r_q.phase >= V_LO) && (r_q.phase <= V_HI));
        emit      = (r_q.phase == PH_LAST) || (realign && (r_q.phase == PH_LATE));
        idx       = realign ? '0 : r_q.phase;
        if (!tx_on) begin
            r_d.phase = '0;
            r_d.votes = '0;
            r_d.last  = samp;
        end else if (os_tick) begin
            r_d.last = samp;
            if (emit) begin
                r_d.bitv  = txin_pkg::vote3(r_q.votes);
                r_d.valid = 1'b1;
            end
            if (idx == V_LO)  r_d.votes[0] = samp;
            if (idx == V_MID) r_d.votes[1] = samp;
            if (idx == V_HI)  r_d.votes[2] = samp;
            r_d.phase = (idx == PH_LAST) ? '0 : idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bit_out   = r_q.bitv;
    assign bit_valid = r_q.valid;

    assert_one_clock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid);
    assert_after_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> $past(os_tick));
    assert_phase_rest_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_on |=> (r_q.phase == '0));
    assert_phase_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_on && !os_tick) |=> $stable(r_q.phase));
endmodule

// File: rtl/txin_oversampler.sv
module txin_oversampler #(
    parameter int unsigned OSR     = 8,
    parameter int unsigned FMT_RAW = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       data_pin,
    input  logic       os_tick,
    input  logic [1:0] fmt_sel,
    input  logic       start_stb,
    input  logic       idle_stb,
    output logic       bit_out,
    output logic       bit_valid
);
    logic pin_s;
    logic tx_on;

    txin_sync #(.STAGES(txin_pkg::SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (data_pin),
        .dout (pin_s)
    );

    txin_gate #(.FMT_W(txin_pkg::FMT_W), .FMT_RAW(FMT_RAW)) i_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .fmt_sel  (fmt_sel),
        .start_stb(start_stb),
        .idle_stb (idle_stb),
        .tx_on    (tx_on)
    );

    txin_recover #(.OSR(OSR)) i_recover (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_on    (tx_on),
        .os_tick  (os_tick),
        .samp     (pin_s),
        .bit_out  (bit_out),
        .bit_valid(bit_valid)
    );

    assert_quiet_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!tx_on) |-> !bit_valid);
endmodule

// File: tb/test_txin_oversampler.sv
module test_txin_oversampler;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int NOM        = 8 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       data_pin = 1'b1;
    logic       os_tick = 1'b0;
    logic [1:0] fmt_sel = 2'd3;
    logic       start_stb = 1'b0;
    logic       idle_stb = 1'b0;
    logic       bit_out;
    logic       bit_valid;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rx_n = 0;
    int dbl = 0;
    logic prev_v = 1'b0;
    logic rx [0:255];
    int   rx_t [0:255];

    txin_oversampler i_txin_oversampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_pin (data_pin),
        .os_tick  (os_tick),
        .fmt_sel  (fmt_sel),
        .start_stb(start_stb),
        .idle_stb (idle_stb),
        .bit_out  (bit_out),
        .bit_valid(bit_valid)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            os_tick = ((cyc % TICK_DIV) == 0);
        end
    end

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (bit_valid && rx_n < 256) begin
            rx[rx_n]   = bit_out;
            rx_t[rx_n] = cyc;
            rx_n       = rx_n + 1;
        end
        if (bit_valid && prev_v) dbl = dbl + 1;
        prev_v = bit_valid;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic go_idle();
        @(negedge clk); idle_stb = 1'b1;
        @(negedge clk); idle_stb = 1'b0;
        repeat (4) @(negedge clk);
        data_pin = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic toggle_line(input int n);
        for (int i = 0; i < n; i++) begin
            data_pin = ~data_pin;
            repeat (NOM / 2) @(negedge clk);
        end
    endtask

    task automatic send(input logic [31:0] pat, input int n, input int per, input int gbit);
        @(negedge clk);
        rx_n = 0;
        start_stb = 1'b1;
        data_pin  = pat[0];
        for (int i = 0; i < n; i++) begin
            data_pin = pat[i];
            if (i == gbit) begin
                repeat (14) @(negedge clk);
                start_stb = 1'b0;
                data_pin = ~pat[i];
                repeat (4) @(negedge clk);
                data_pin = pat[i];
                repeat (per - 18) @(negedge clk);
            end else begin
                @(negedge clk);
                start_stb = 1'b0;
                repeat (per - 1) @(negedge clk);
            end
        end
        repeat (NOM + 8) @(negedge clk);
    endtask

    task automatic compare(input logic [31:0] pat, input int n, input string tag);
        chk(rx_n >= n, {tag, " count"}, rx_n, n);
        for (int i = 0; i < n; i++) begin
            if (i < rx_n) chk(rx[i] == pat[i], tag, int'(rx[i]), int'(pat[i]));
        end
    endtask

    task automatic t_reset();
        chk(bit_valid == 1'b0, "R1 valid after reset", int'(bit_valid), 0);
        chk(bit_out == 1'b0, "R1 bit after reset", int'(bit_out), 0);
    endtask

    task automatic t_nominal();
        send(32'h0F96_A5C2, 32, NOM, -1);
        compare(32'h0F96_A5C2, 32, "R7 nominal stream");
        go_idle();
    endtask

    task automatic t_drift(input int per, input string tag);
        send(32'h00DB_4CB2, 24, per, -1);
        compare(32'h00DB_4CB2, 24, tag);
        go_idle();
    endtask

    task automatic t_glitch();
        send(32'h0000_0096, 8, NOM, 2);
        compare(32'h0000_0096, 8, "R6 glitch in voting window");
        go_idle();
    endtask

    task automatic t_steady();
        @(negedge clk);
        rx_n = 0;
        dbl = 0;
        data_pin = 1'b1;
        start_stb = 1'b1;
        @(negedge clk); start_stb = 1'b0;
        repeat (12 * NOM) @(negedge clk);
        chk(rx_n >= 10, "R5 steady line count", rx_n, 10);
        for (int k = 0; k + 1 < rx_n && k < 9; k++) begin
            chk(rx_t[k+1] - rx_t[k] == NOM, "R5 bit spacing", rx_t[k+1] - rx_t[k], NOM);
            chk(rx[k] == 1'b1, "R5 steady level", int'(rx[k]), 1);
        end
        chk(dbl == 0, "R9 valid one clock", dbl, 0);
        go_idle();
    endtask

    task automatic t_wrong_mode();
        fmt_sel = 2'd1;
        @(negedge clk);
        rx_n = 0;
        start_stb = 1'b1;
        @(negedge clk); start_stb = 1'b0;
        toggle_line(10);
        chk(rx_n == 0, "R2 start ignored outside mode", rx_n, 0);
        fmt_sel = 2'd3;
        go_idle();
    endtask

    task automatic t_idle_stop();
        @(negedge clk);
        rx_n = 0;
        start_stb = 1'b1;
        @(negedge clk); start_stb = 1'b0;
        toggle_line(6);
        chk(rx_n > 0, "R3 running before idle", rx_n, 1);
        @(negedge clk); idle_stb = 1'b1;
        @(negedge clk); idle_stb = 1'b0;
        @(negedge clk);
        rx_n = 0;
        toggle_line(10);
        chk(rx_n == 0, "R3 quiet after idle", rx_n, 0);
        go_idle();
    endtask

    task automatic t_both_strobes();
        @(negedge clk);
        rx_n = 0;
        start_stb = 1'b1;
        idle_stb  = 1'b1;
        @(negedge clk);
        start_stb = 1'b0;
        idle_stb  = 1'b0;
        toggle_line(10);
        chk(rx_n == 0, "R3 idle beats start", rx_n, 0);
        go_idle();
    endtask

    task automatic t_mode_leave();
        @(negedge clk);
        rx_n = 0;
        start_stb = 1'b1;
        @(negedge clk); start_stb = 1'b0;
        toggle_line(6);
        chk(rx_n > 0, "R4 running before mode change", rx_n, 1);
        fmt_sel = 2'd0;
        repeat (2) @(negedge clk);
        rx_n = 0;
        toggle_line(6);
        chk(rx_n == 0, "R4 quiet after mode change", rx_n, 0);
        fmt_sel = 2'd3;
        toggle_line(6);
        chk(rx_n == 0, "R4 no resume without start", rx_n, 0);
        go_idle();
    endtask

    bit done = 1'b0;

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_nominal();
        t_drift(NOM - 2, "R8 fast host");
        t_drift(NOM + 2, "R8 slow host");
        t_glitch();
        t_steady();
        t_wrong_mode();
        t_idle_stop();
        t_both_strobes();
        t_mode_leave();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule